// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Engine

This block is the controller side of a three-wire serial link to a display panel. Every word on the wire is nine bits wide. The top bit tells the panel whether the word is an opcode (bit 8 = 0) or an argument byte (bit 8 = 1). The engine takes one request that holds an opcode and an argument count. It sends the opcode word, then pulls that many bytes from a byte stream and sends each one as an argument word. Each word is framed by its own active-low select pulse.

A request can instead ask for an identification read. The engine then sends the fixed read opcode as a command word and clocks one nine-bit read word, which it throws away. That word supplies the extra clock the panel needs before its first data bit. The engine then clocks an eight-bit read word and returns it as the identification byte. The serial clock is the system clock divided by `2*HALF_DIV`. The default gives 1 MHz from a 50 MHz system clock.

Both data interfaces use valid/ready. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the engine is idle, so a request offered while it is busy is neither taken nor remembered. Argument bytes are taken on a cycle where `prm_valid` and `prm_ready` are both high. The byte source may hold `prm_valid` low for any number of cycles, and the engine waits with the link quiet until a byte arrives.

Top module: `panel9_link`

## Requirements
- R1: A command word is 9 bits with bit 8 = 0 and the opcode in bits 7:0.
- R2: After the command word, exactly `req_count` argument words follow. Each is 9 bits with bit 8 = 1 and one stream byte in bits 7:0, in stream order.
- R3: A request with `req_count` = 0 produces exactly one word on the wire, the command word.
- R4: Bits go out most significant first. `sclk` idles low, `mosi` changes only while `sclk` is low, and `miso` is sampled at each rising edge of `sclk`.
- R5: `cs_n` falls before the first rising edge of `sclk` in each word. `cs_n` changes only while `sclk` is low. Between two words `cs_n` stays high for at least `2*HALF_DIV` clock cycles.
- R6: An identification read (`req_read` = 1, `req_opcode` ignored) puts three words on the wire, in this order:
  - the 9-bit command word 0x004;
  - a 9-bit read word whose sampled bits are discarded;
  - an 8-bit read word.

  The 8 bits sampled during the 8-bit read word, first bit as bit 7, appear on `id_data`. `id_data` changes only in the cycle where `done` is high.
- R7: `req_ready` is high only while `busy` is low. A request offered while busy is ignored and leaves no trace on the wire.
- R8: `prm_ready` is high only while the engine waits for an argument byte, and the engine takes exactly `req_count` bytes per request. A byte still offered after the request completes stays untaken.
- R9: `done` is high for exactly one cycle, in the first cycle after a transaction where `busy` is low. For a zero-argument command, `done` is high after exactly `20*HALF_DIV` clock edges following the edge that accepted the request.
- R10: During reset, all of the following hold:
  - `cs_n` = 1;
  - `sclk` = 0, `mosi` = 0;
  - `busy` = 0, `done` = 0;
  - `req_ready` = 1;
  - `id_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle; request taken when both high |
| req_read | input | 1 | 1 = identification read, 0 = command with arguments |
| req_opcode | input | 8 | Command opcode |
| req_count | input | CNT_W | Number of argument bytes |
| prm_valid | input | 1 | Argument byte offered |
| prm_ready | output | 1 | Engine waiting for an argument byte |
| prm_data | input | 8 | Argument byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| id_data | output | 8 | Last identification byte |
| cs_n | output | 1 | Active-low word select |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to panel |
| miso | input | 1 | Serial data from panel |

## Verification
A word occupies `2*HALF_DIV` cycles per bit plus a `2*HALF_DIV`-cycle select gap. A zero-argument command's `done` is therefore due exactly `20*HALF_DIV` edges after the accepting edge. The bench samples one cycle before and at that edge, one time unit after the clock, so an extra or missing register shows up. Every other result is checked once `busy` has dropped, against words recorded by a panel model that shifts on `sclk` edges. Because of this, the only timing those checks depend on is the select-gap width, which the model measures in clock cycles.

// File: rtl/p9_pkg.sv
package p9_pkg;
  localparam int WORD_W = 9;
  localparam int LEN_W  = $clog2(WORD_W + 1);

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH, SH_GAP} sh_state_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_CMD, SQ_FETCH, SQ_PARAM, SQ_IDCMD, SQ_DUMMY, SQ_READ
  } sq_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] bits;
    logic [LEN_W-1:0]  len;
  } word_req_t;
endpackage

// File: rtl/p9_phase_timer.sv
module p9_phase_timer #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic long_ph,
  output logic tick
);
  localparam int GAP_DIV = 2 * HALF_DIV;
  localparam int CW      = $clog2(GAP_DIV + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = long_ph ? CW'(GAP_DIV - 1) : CW'(HALF_DIV - 1);
  assign tick = !clr && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(GAP_DIV - 1));
endmodule

// File: rtl/p9_word_shifter.sv
module p9_word_shifter
  import p9_pkg::*;
#(
  parameter int HALF_DIV = 25
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  word_req_t wreq,
  input  logic      miso,
  output logic      cs_n,
  output logic      sclk,
  output logic      mosi,
  output logic      wdone,
  output logic [7:0] rx_byte
);
  sh_state_e          st;
  logic [WORD_W-1:0]  sh;
  logic [LEN_W-1:0]   left;
  logic [7:0]         rx;
  logic               tick;
  logic               load;

  p9_phase_timer #(.HALF_DIV(HALF_DIV)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st == SH_IDLE),
    .long_ph (st == SH_GAP),
    .tick    (tick)
  );

  assign wdone   = (st == SH_GAP) && tick;
  assign load    = start && ((st == SH_IDLE) || wdone);
  assign mosi    = sh[WORD_W-1];
  assign rx_byte = rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= SH_IDLE;
      cs_n <= 1'b1;
      sclk <= 1'b0;
      sh   <= '0;
      left <= '0;
      rx   <= '0;
    end else if (load) begin
      st   <= SH_LOW;
      cs_n <= 1'b0;
      sclk <= 1'b0;
      sh   <= wreq.bits;
      left <= wreq.len;
      rx   <= '0;
    end else begin
      case (st)
        SH_LOW: if (tick) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
          st   <= SH_HIGH;
        end
        SH_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (left == LEN_W'(1)) begin
            cs_n <= 1'b1;
            sh   <= '0;
            st   <= SH_GAP;
          end else begin
            sh   <= {sh[WORD_W-2:0], 1'b0};
            left <= left - 1'b1;
            st   <= SH_LOW;
          end
        end
        SH_GAP: if (tick) st <= SH_IDLE;
        default: ;
      endcase
    end
  end

  // R4
  mosi_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> !sclk);
  // R5
  cs_edge_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_n) |-> !sclk);
  // R5
  rise_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> !cs_n);
  // R4
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
endmodule

// File: rtl/p9_sequencer.sv
module p9_sequencer
  import p9_pkg::*;
#(
  parameter int          CNT_W     = 8,
  parameter logic [7:0]  ID_OPCODE = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_read,
  input  logic [7:0]       req_opcode,
  input  logic [CNT_W-1:0] req_count,
  input  logic             prm_valid,
  input  logic [7:0]       prm_data,
  input  logic             wdone,
  input  logic [7:0]       rx_byte,
  output logic             req_ready,
  output logic             prm_ready,
  output logic             start,
  output word_req_t        wreq,
  output logic             busy,
  output logic             done,
  output logic [7:0]       id_data
);
  sq_state_e        st;
  logic [CNT_W-1:0] remain;
  logic             fire;
  logic             take;

  assign req_ready = (st == SQ_IDLE);
  assign prm_ready = (st == SQ_FETCH);
  assign busy      = (st != SQ_IDLE);
  assign fire      = req_valid && req_ready;
  assign take      = prm_valid && prm_ready;

  always_comb begin
    start     = 1'b0;
    wreq.bits = '0;
    wreq.len  = LEN_W'(WORD_W);
    if (fire) begin
      start     = 1'b1;
      wreq.bits = {1'b0, (req_read ? ID_OPCODE : req_opcode)};
    end else if (take) begin
      start     = 1'b1;
      wreq.bits = {1'b1, prm_data};
    end else if (wdone && (st == SQ_IDCMD)) begin
      start     = 1'b1;
    end else if (wdone && (st == SQ_DUMMY)) begin
      start     = 1'b1;
      wreq.len  = LEN_W'(8);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      remain  <= '0;
      done    <= 1'b0;
      id_data <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        SQ_IDLE: if (fire) begin
          remain <= req_count;
          st     <= req_read ? SQ_IDCMD : SQ_CMD;
        end
        SQ_CMD, SQ_PARAM: if (wdone) begin
          if (remain == '0) begin
            st   <= SQ_IDLE;
            done <= 1'b1;
          end else begin
            st <= SQ_FETCH;
          end
        end
        SQ_FETCH: if (take) begin
          remain <= remain - 1'b1;
          st     <= SQ_PARAM;
        end
        SQ_IDCMD: if (wdone) st <= SQ_DUMMY;
        SQ_DUMMY: if (wdone) st <= SQ_READ;
        SQ_READ: if (wdone) begin
          id_data <= rx_byte;
          st      <= SQ_IDLE;
          done    <= 1'b1;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R7
  busy_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));
  // R6
  id_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_data != $past(id_data)) |-> done);
  // R8
  fetch_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prm_ready |-> (remain != '0));
endmodule

// File: rtl/panel9_link.sv
module panel9_link
  import p9_pkg::*;
#(
  parameter int          HALF_DIV  = 25,
  parameter int          CNT_W     = 8,
  parameter logic [7:0]  ID_OPCODE = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_read,
  input  logic [7:0]       req_opcode,
  input  logic [CNT_W-1:0] req_count,
  input  logic             prm_valid,
  output logic             prm_ready,
  input  logic [7:0]       prm_data,
  output logic             busy,
  output logic             done,
  output logic [7:0]       id_data,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso
);
  logic      start;
  logic      wdone;
  word_req_t wreq;
  logic [7:0] rx_byte;

  p9_sequencer #(.CNT_W(CNT_W), .ID_OPCODE(ID_OPCODE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_read   (req_read),
    .req_opcode (req_opcode),
    .req_count  (req_count),
    .prm_valid  (prm_valid),
    .prm_data   (prm_data),
    .wdone      (wdone),
    .rx_byte    (rx_byte),
    .req_ready  (req_ready),
    .prm_ready  (prm_ready),
    .start      (start),
    .wreq       (wreq),
    .busy       (busy),
    .done       (done),
    .id_data    (id_data)
  );

  p9_word_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .wreq    (wreq),
    .miso    (miso),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .mosi    (mosi),
    .wdone   (wdone),
    .rx_byte (rx_byte)
  );

  // R7
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);
  // R8
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prm_ready |-> cs_n);
endmodule

// File: tb/panel9_link_bench.sv
module panel9_link_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HD         = 2;

  typedef struct packed {
    logic [7:0]  op;
    logic [2:0]  cnt;
    logic [31:0] prm;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{8'h11, 3'd0, 32'h0},
    '{8'h36, 3'd1, 32'h08000000},
    '{8'hB6, 3'd4, 32'h22E2FF04},
    '{8'hC5, 3'd2, 32'h006A0000},
    '{8'h29, 3'd0, 32'h0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0;
  logic [7:0] req_opcode = '0, req_count = '0;
  logic prm_valid, prm_ready, req_ready, busy, done;
  logic [7:0] prm_data, id_data;
  logic cs_n, sclk, mosi, miso = 1'b0;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel9_link #(.HALF_DIV(HD)) u_panel9_link (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_opcode(req_opcode), .req_count(req_count),
    .prm_valid(prm_valid), .prm_ready(prm_ready), .prm_data(prm_data),
    .busy(busy), .done(done), .id_data(id_data),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  // panel model: records each selected word and serves read data
  logic [8:0] log_w [0:255];
  int         log_n [0:255];
  int nlog = 0, nb = 0, phase = 0, cyc = 0, rise_cyc = 0, min_gap = 1000;
  int idle_clk_err = 0, done_cnt = 0;
  logic [8:0] sr = '0, mo = '0;
  logic [7:0] id_byte = '0;
  bit rd_mode = 0;

  always @(negedge clk) begin
    cyc++;
    if (cs_n && sclk) idle_clk_err++;
    if (rst_n && done) done_cnt++;
  end

  always @(negedge cs_n) begin
    if (nlog > 0 && (cyc - rise_cyc) < min_gap) min_gap = cyc - rise_cyc;
    sr = '0; nb = 0;
    if (phase == 1)      mo = 9'h1A5;
    else if (phase == 2) mo = {id_byte, 1'b0};
    else                 mo = '0;
    miso = mo[8];
  end

  always @(posedge sclk) if (!cs_n) begin
    sr = {sr[7:0], mosi}; nb++;
  end

  always @(negedge sclk) if (!cs_n) begin
    mo = {mo[7:0], 1'b0}; miso = mo[8];
  end

  always @(posedge cs_n) if (rst_n) begin
    rise_cyc = cyc;
    log_w[nlog] = sr; log_n[nlog] = nb; nlog++;
    if (phase == 1)                              phase = 2;
    else if (phase == 2)                         phase = 0;
    else if (rd_mode && nb == 9 && sr == 9'h004) phase = 1;
  end

  // argument byte source with stalls
  logic [7:0] fbuf [0:63];
  int fidx = 0, fcount = 0, stall = 0;
  logic hs = 1'b0;
  always @(posedge clk) hs <= prm_valid & prm_ready;
  initial begin
    prm_valid = 1'b0; prm_data = '0;
    forever begin
      @(negedge clk);
      if (hs) begin fidx++; stall = fidx % 3; prm_valid = 1'b0; end
      if (stall > 0) begin stall--; prm_valid = 1'b0; end
      else if (fidx < fcount) begin prm_valid = 1'b1; prm_data = fbuf[fidx]; end
      else prm_valid = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic rd, input logic [7:0] op, input logic [7:0] cnt);
    @(negedge clk);
    req_valid = 1'b1; req_read = rd; req_opcode = op; req_count = cnt;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int k = 0;
    do begin @(negedge clk); k++; end while (busy && k < 5000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    int base, dc;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 cs_n", cs_n, 1); chk("R10 sclk", sclk, 0); chk("R10 mosi", mosi, 0);
    chk("R10 busy", busy, 0); chk("R10 done", done, 0);
    chk("R10 req_ready", req_ready, 1); chk("R10 id_data", id_data, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: commands with 0..4 arguments
    for (int v = 0; v < 5; v++) begin
      base = nlog; dc = done_cnt;
      @(posedge clk);
      for (int i = 0; i < int'(VEC[v].cnt); i++) fbuf[fcount + i] = VEC[v].prm[31 - 8*i -: 8];
      fcount = fcount + int'(VEC[v].cnt);
      issue(1'b0, VEC[v].op, {5'd0, VEC[v].cnt});
      wait_idle();
      @(negedge clk);
      chk("R2 R3 word count", nlog - base, 1 + int'(VEC[v].cnt));
      chk("R1 R4 command word", log_w[base], {1'b0, VEC[v].op});
      chk("R1 command length", log_n[base], 9);
      for (int i = 0; i < int'(VEC[v].cnt); i++) begin
        chk("R2 R4 argument word", log_w[base+1+i], {1'b1, VEC[v].prm[31 - 8*i -: 8]});
        chk("R2 argument length", log_n[base+1+i], 9);
      end
      chk("R8 bytes taken", fidx, fcount);
      chk("R9 one done pulse", done_cnt - dc, 1);
    end

    // R9 exact latency for a zero-argument command
    @(negedge clk);
    req_valid = 1'b1; req_read = 1'b0; req_opcode = 8'h29; req_count = 8'd0;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    for (int k = 1; k <= 20*HD; k++) begin
      @(posedge clk); #1;
      if (k == 20*HD - 1) chk("R9 done early", done, 0);
      if (k == 20*HD)     chk("R9 done due", done, 1);
    end
    wait_idle();

    // R7 request while busy is ignored
    base = nlog;
    @(posedge clk); fbuf[fcount] = 8'h66; fcount++;
    issue(1'b0, 8'h3A, 8'd1);
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_opcode = 8'h55; req_count = 8'd0;
    @(negedge clk); chk("R7 ready low while busy", req_ready, 0);
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    chk("R7 no extra words", nlog - base, 2);
    chk("R7 original opcode kept", log_w[base], 9'h03A);
    chk("R7 idle afterwards", busy, 0);

    // R8 surplus byte is left in the stream
    base = fidx;
    @(posedge clk);
    fbuf[fcount] = 8'hAA; fbuf[fcount+1] = 8'h55; fbuf[fcount+2] = 8'h77;
    fcount = fcount + 3;
    issue(1'b0, 8'hC1, 8'd2);
    wait_idle();
    repeat (6) @(negedge clk);
    chk("R8 exact byte count", fidx - base, 2);
    chk("R8 ready low after", prm_ready, 0);
    @(posedge clk); fcount = fidx;

    // R6 identification reads
    rd_mode = 1;
    id_byte = 8'h80; base = nlog;
    issue(1'b1, 8'hFF, 8'd3);
    wait_idle();
    @(negedge clk);
    chk("R6 word count", nlog - base, 3);
    chk("R6 id command", log_w[base], 9'h004);
    chk("R6 dummy length", log_n[base+1], 9);
    chk("R6 read length", log_n[base+2], 8);
    chk("R6 R4 id 80", id_data, 8'h80);
    id_byte = 8'h5C;
    issue(1'b1, 8'h00, 8'd0);
    wait_idle();
    @(negedge clk);
    chk("R6 R4 id 5C", id_data, 8'h5C);

    // R5 select gap and R4 idle clock
    chk("R5 min gap", (min_gap >= 2*HD), 1);
    chk("R4 clock low when deselected", idle_clk_err, 0);
    finish_run();
  end
endmodule